// File: doc/BRIEF.md
# Interrupt Pending Flag Register

This block keeps the pending state of twelve maskable interrupt lines, which occupy flag positions 4 through 15, and one non-maskable interrupt, which sits at flag position 1. The lines are watched for rising edges, and each edge marks its flag pending. Software can force individual maskable flags high through a set-write port and low through a clear-write port. A per-bit acknowledge input drops a flag when its interrupt is taken. The whole 16-bit flag word is always presented on an output for software reads.

Several rules decide what happens when events meet on the same bit:

- A hardware arrival beats both a software clear and an acknowledge.
- A software set beats a software clear.
- Software writes pass through one staging register, so a write becomes visible in the flag word one cycle later than a hardware event would. This leaves one delay slot between the write and the first read that shows it.

The non-maskable flag and the unused low positions cannot be reached by software writes.

Reset is an asynchronous active-low input. Inside the block its release is synchronised to the clock, so the block leaves reset a few edges after the input goes high.

Top module: `irq_pend_flags`

## Requirements
- R1: While reset is asserted the flag word reads 0x0000, the non-maskable flag included. Asserting reset clears the flags at once, without waiting for a clock edge.
- R2: A low-to-high change on line k (input bit k-4) sets flag bit k at the first clock edge that samples the line high. The change shows on the flag output right after that edge.
- R3: A line held high sets its flag only once. After software clears that flag, the flag stays 0 for as long as the line stays high.
- R4: A write to the set port with bit n = 1 (n from 4 to 15) makes flag n = 1. A write to the clear port with bit n = 1 makes flag n = 0. Data bits that are 0 leave their flags as they were.
- R5: A set or clear write sampled at clock edge t changes the flag word at edge t+1. A read between edges t and t+1 still returns the old value.
- R6: When the set and clear ports both write 1 to the same bit in the same cycle, that flag ends up 1.
- R7: When a line's rising edge and a staged clear take effect on the same clock edge for the same bit, that flag ends up 1.
- R8: An acknowledge bit n = 1 clears flag n at the edge that samples it, with no staging delay. A rising edge on line n sampled at the same edge keeps the flag at 1.
- R9: A rising edge on the non-maskable input sets flag bit 1. Set and clear writes never change bit 1. Acknowledge bit 1 clears it.
- R10: Flag bits 0, 2 and 3 always read 0, whatever is written to the set or clear ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| irq_in | input | 12 | Maskable interrupt lines; bit j drives flag bit j+4 |
| nmi_in | input | 1 | Non-maskable interrupt line |
| set_we | input | 1 | Write strobe for the set port |
| set_data | input | 16 | Set mask; a 1 at bit n sets flag n |
| clr_we | input | 1 | Write strobe for the clear port |
| clr_data | input | 16 | Clear mask; a 1 at bit n clears flag n |
| ack_in | input | 16 | Acknowledge per bit; a 1 clears that flag at once |
| flag_out | output | 16 | Pending flag word |

## Verification
The bench targets the collisions on a single bit:

- **Set and clear together.** A design where the clear wins would read 0 where 1 is expected.
- **Clear or acknowledge meeting an arrival.** A design that lets software or the acknowledge beat hardware would lose the interrupt.
- **A line held high after a clear.** A level-sensitive design would set the flag again at once.

It also reads the flag word inside the delay slot. A design without the staging register would already show the new value there. A design with one stage too many would still show the old value a cycle later. Sweeps over many set and clear masks check that writes never reach bit 1 or bits 0, 2 and 3. A design that did not mask them would show nonzero low bits or a lost non-maskable flag.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int FLAG_W    = 16;
  localparam int LINE_LO   = 4;
  localparam int LINE_HI   = 15;
  localparam int NMI_POS   = 1;
  localparam int NUM_LINES = LINE_HI - LINE_LO + 1;
  localparam int RST_STAGES = 2;

  function automatic logic [FLAG_W-1:0] line_mask();
    logic [FLAG_W-1:0] m;
    m = '0;
    for (int b = LINE_LO; b <= LINE_HI; b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [FLAG_W-1:0] LINE_MASK  = line_mask();
  localparam logic [FLAG_W-1:0] VALID_MASK = LINE_MASK | (FLAG_W'(1) << NMI_POS);
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;
  logic         prev_en;

  always_comb begin
    prev_en = |(lvl_in ^ prev_q);
    rise    = lvl_in & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= lvl_in;
  end

  // R3: a level that stays high yields one pulse only
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_write_stage.sv
module irq_write_stage
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [FLAG_W-1:0] set_data,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_data,
  output logic [FLAG_W-1:0] stg_set,
  output logic [FLAG_W-1:0] stg_clr
);
  logic [FLAG_W-1:0] set_d, clr_d;
  logic              stg_en;

  always_comb begin
    set_d  = set_we ? (set_data & LINE_MASK) : '0;
    clr_d  = clr_we ? (clr_data & LINE_MASK) : '0;
    stg_en = set_we | clr_we | (|stg_set) | (|stg_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_set <= '0;
      stg_clr <= '0;
    end else if (stg_en) begin
      stg_set <= set_d;
      stg_clr <= clr_d;
    end
  end

  // R5: a strobe-free cycle leaves nothing staged for the following edge
  assert_idle_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> (stg_set == '0 && stg_clr == '0));
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
  import irq_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_rise,
  input  logic                 nmi_rise,
  input  logic [FLAG_W-1:0]    stg_set,
  input  logic [FLAG_W-1:0]    stg_clr,
  input  logic [FLAG_W-1:0]    ack,
  output logic [FLAG_W-1:0]    flags
);
  logic [FLAG_W-1:0] rise_full;
  logic [FLAG_W-1:0] ack_m;
  logic [FLAG_W-1:0] flags_nxt;
  logic              flag_en;

  always_comb begin
    rise_full                  = '0;
    rise_full[LINE_HI:LINE_LO] = line_rise;
    rise_full[NMI_POS]         = nmi_rise;
    ack_m                      = ack & VALID_MASK;
    flag_en = (|rise_full) | (|stg_set) | (|stg_clr) | (|ack_m) | (|ack);
  end

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (b >= LINE_LO && b <= LINE_HI) begin : g_line
      assign flags_nxt[b] = rise_full[b] | stg_set[b] |
                            (flags[b] & ~stg_clr[b] & ~ack_m[b]);
    end else if (b == NMI_POS) begin : g_nmi
      assign flags_nxt[b] = rise_full[b] | (flags[b] & ~ack_m[b]);
    end else begin : g_none
      assign flags_nxt[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_en) flags <= flags_nxt;
  end

  // R2, R7: a detected edge is pending after the edge that sees it
  assert_arrival_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_full) |=> ((flags & $past(rise_full)) == $past(rise_full)));
  // R6: a staged set always lands, whatever the clear says
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|stg_set) |=> ((flags & $past(stg_set)) == $past(stg_set)));
  // R4: a staged clear with no competing event drops the bit
  assert_clear_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(stg_clr & ~stg_set & ~rise_full)) == '0));
  // R8: an acknowledge with no arrival drops the bit at once
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(ack_m & ~rise_full & ~stg_set)) == '0));
  // R3: no flag rises without an edge or a staged set behind it
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(rise_full | stg_set)) == '0));
  // R9: the non-maskable bit moves only on its own edge or acknowledge
  assert_nmi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_rise && !ack[NMI_POS]) |=> $stable(flags[NMI_POS]));
endmodule

// File: rtl/irq_pend_flags.sv
module irq_pend_flags
  import irq_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic                 set_we,
  input  logic [FLAG_W-1:0]    set_data,
  input  logic                 clr_we,
  input  logic [FLAG_W-1:0]    clr_data,
  input  logic [FLAG_W-1:0]    ack_in,
  output logic [FLAG_W-1:0]    flag_out
);
  logic                 rst_s_n;
  logic [NUM_LINES:0]   rise_all;
  logic [FLAG_W-1:0]    stg_set, stg_clr;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  irq_edge_detect #(.W(NUM_LINES + 1)) u_edge (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .lvl_in ({nmi_in, irq_in}),
    .rise   (rise_all)
  );

  irq_write_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .stg_set  (stg_set),
    .stg_clr  (stg_clr)
  );

  irq_flag_core u_core (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .line_rise (rise_all[NUM_LINES-1:0]),
    .nmi_rise  (rise_all[NUM_LINES]),
    .stg_set   (stg_set),
    .stg_clr   (stg_clr),
    .ack       (ack_in),
    .flags     (flag_out)
  );

  // R10: unimplemented low positions stay empty
  assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (set_we || clr_we) |=> ((flag_out & ~VALID_MASK) == '0));
endmodule

// File: tb/irq_pend_flags_test.sv
module irq_pend_flags_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] irq_in;
  logic        nmi_in;
  logic        set_we, clr_we;
  logic [15:0] set_data, clr_data, ack_in;
  logic [15:0] flag_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] MASK = 16'hFFF0;

  always #2 clk = ~clk;

  irq_pend_flags uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .set_we(set_we), .set_data(set_data), .clr_we(clr_we),
    .clr_data(clr_data), .ack_in(ack_in), .flag_out(flag_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_set(input logic [15:0] d);
    set_we = 1'b1; set_data = d; step(); set_we = 1'b0; set_data = '0; step();
  endtask

  task automatic wr_clr(input logic [15:0] d);
    clr_we = 1'b1; clr_data = d; step(); clr_we = 1'b0; clr_data = '0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; nmi_in = 1'b0; set_we = 1'b0; clr_we = 1'b0;
    set_data = '0; clr_data = '0; ack_in = '0;
    repeat (3) step();
    chk("R1 reset value", flag_out, 16'h0000);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 after release", flag_out, 16'h0000);

    // per-line sweep: edge, delayed clear, held level, delayed set, acknowledge
    for (int i = 4; i < 16; i++) begin
      logic [15:0] b;
      b = 16'(1) << i;
      irq_in[i-4] = 1'b1; step();
      chk("R2 edge sets", flag_out, b);
      clr_we = 1'b1; clr_data = b; step();
      chk("R5 clear delay slot", flag_out, b);
      clr_we = 1'b0; clr_data = '0; step();
      chk("R4 clear applied", flag_out, 16'h0000);
      step();
      chk("R3 held level no reset", flag_out, 16'h0000);
      irq_in[i-4] = 1'b0; step();
      set_we = 1'b1; set_data = b; step();
      chk("R5 set delay slot", flag_out, 16'h0000);
      set_we = 1'b0; set_data = '0; step();
      chk("R4 set applied", flag_out, b);
      ack_in = b; step(); ack_in = '0;
      chk("R8 ack clears at once", flag_out, 16'h0000);
    end

    // R6: set and clear collide on every bit
    set_we = 1'b1; set_data = 16'hFFFF; clr_we = 1'b1; clr_data = 16'hFFFF; step();
    set_we = 1'b0; clr_we = 1'b0; set_data = '0; clr_data = '0; step();
    chk("R6 set beats clear", flag_out, MASK);
    chk("R10 low bits zero", flag_out & 16'h000F, 16'h0000);

    // R7: staged clear meets an arrival on bit 5
    clr_we = 1'b1; clr_data = 16'hFFFF; step();
    clr_we = 1'b0; clr_data = '0; irq_in[1] = 1'b1; step();
    chk("R7 arrival beats clear", flag_out, 16'h0020);

    // R8: ack meets an arrival on bit 6, plain ack on bit 5
    irq_in[1] = 1'b0; step();
    irq_in[2] = 1'b1; ack_in = 16'h0060; step(); ack_in = '0;
    chk("R8 arrival beats ack", flag_out, 16'h0040);

    // R9: non-maskable flag
    nmi_in = 1'b1; step();
    chk("R9 nmi edge sets", flag_out, 16'h0042);
    wr_clr(16'h000F);
    chk("R9 clear cannot touch nmi", flag_out, 16'h0042);
    ack_in = 16'h0002; step(); ack_in = '0;
    chk("R9 ack clears nmi", flag_out, 16'h0040);
    wr_set(16'h000F);
    chk("R10 set to low bits ignored", flag_out, 16'h0040);
    step();
    chk("R9 held nmi no reset", flag_out, 16'h0040);
    nmi_in = 1'b0; irq_in = '0;

    // R4: strobes with all-zero data
    wr_set(16'h0000);
    wr_clr(16'h0000);
    chk("R4 zero data no effect", flag_out, 16'h0040);

    // R4/R10: mask sweep
    for (int k = 0; k < 24; k++) begin
      logic [15:0] p, q;
      p = 16'((k * 16'h1357) ^ (k << 9) ^ 16'h5A5A);
      q = 16'((k * 16'h2B1D) ^ 16'h33CC);
      wr_clr(16'hFFFF);
      wr_set(p);
      chk("R4 sweep set", flag_out, p & MASK);
      wr_clr(q);
      chk("R4 sweep clear", flag_out, p & ~q & MASK);
    end

    // R1: asynchronous reset with flags pending
    wr_set(16'hA5A0);
    nmi_in = 1'b1; step();
    chk("R1 pre-reset state", flag_out, 16'hA5A2);
    rst_n = 1'b0; #1;
    chk("R1 async clear", flag_out, 16'h0000);
    step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule